// File: doc/BRIEF.md
# ECC Error Capture and Status Logger

This block sits next to a SECDED-protected SDRAM read path (64 data bits plus 8 check bits). Each read the decoder finishes may come with a correctable or an uncorrectable error indication, the 8-bit syndrome and the failing address. The logger turns these events into one 32-bit status word for software. It records the first error only: its address (upper 19 bits) and syndrome, and a sticky flag for a single-bit or a multi-bit error. It holds the record until software clears both flags together with a write of ones.

The same word holds three read/write controls. One disables the scrub write-back that the block otherwise asks for after every corrected read. The other two enable the non-maskable interrupt level for single-bit errors and the system-error level for multi-bit errors. A global ECC enable input gates all logging and scrubbing.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset the status word reads 0, and `nmi_o`, `serr_o` and `scrub_req_o` are low.
- R2: When both flags are clear, a correctable error (`ev_valid`, `ev_ce`, no `ev_ue`, `ecc_en` high) sets the single-bit flag (bit 0). It also loads address bits 31:13 into status bits 30:12 and the syndrome into bits 11:4. All of this can be read in the cycle after the event.
- R3: An uncorrectable error sets the multi-bit flag (bit 1) and captures address and syndrome the same way. When both indications arrive in the same cycle, only the multi-bit flag is set.
- R4: While either flag is set, later errors are not recorded: the other flag stays 0 and status bits 30:4 stay frozen.
- R5: A write with data bits 1:0 equal to 2'b11 clears both flags. A write with 2'b01, 2'b10 or 2'b00 in those bits leaves both flags unchanged.
- R6: Every write loads status bits 31, 3 and 2 from the write data. Written values in bits 30:4 and 1:0 are not stored as data.
- R7: `nmi_o` is high exactly when the single-bit flag and bit 2 are both 1. `serr_o` is high exactly when the multi-bit flag and bit 3 are both 1.
- R8: A correctable-only event with `ecc_en` high and bit 31 equal to 0 makes `scrub_req_o` high for one cycle, in the cycle after the event. In that cycle `scrub_addr_o` carries the event address. This happens whether or not the error was logged. With bit 31 set to 1, no scrub is requested.
- R9: While `ecc_en` is low, events set no flag, change no captured field and request no scrub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_en | input | 1 | Global ECC checking enable |
| ev_valid | input | 1 | A decoded read result is present this cycle |
| ev_ce | input | 1 | Correctable (single-bit) error on this read |
| ev_ue | input | 1 | Uncorrectable (multi-bit) error on this read |
| ev_addr | input | ADDR_W | Address of the read |
| ev_syn | input | SYN_W | Syndrome of the read |
| reg_we | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Status word |
| nmi_o | output | 1 | Non-maskable interrupt level for single-bit errors |
| serr_o | output | 1 | System-error level for multi-bit errors |
| scrub_req_o | output | 1 | One-cycle scrub write-back request |
| scrub_addr_o | output | ADDR_W | Address to scrub, valid with the request |

## Verification
The assertions assume `ev_ce` and `ev_ue` mean something only when `ev_valid` is high, and that inputs are stable around the rising edge. The random stimulus changes inputs only at falling edges and draws the error indications, enable and writes independently. This lets both indications arrive together, events arrive during clear writes, and partial clear patterns occur. A bench model computes the expected status word and outputs every cycle. Directed sequences pin down the one-error-at-a-time rule, the clear rule and the scrub gating.

// File: rtl/ecc_err_logger.sv
module ecc_err_logger #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_en,
  input  logic              ev_valid,
  input  logic              ev_ce,
  input  logic              ev_ue,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [SYN_W-1:0]  ev_syn,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              nmi_o,
  output logic              serr_o,
  output logic              scrub_req_o,
  output logic [ADDR_W-1:0] scrub_addr_o
);
  localparam int KEEP_W = 19;
  localparam int LOW_W  = ADDR_W - KEEP_W;

  logic              sbe_q, mbe_q;
  logic              scrub_off_q, serr_en_q, nmi_en_q;
  logic [KEEP_W-1:0] addr_q;
  logic [SYN_W-1:0]  syn_q;

  wire hit      = ev_valid & ecc_en & (ev_ce | ev_ue);
  wire idle     = ~sbe_q & ~mbe_q;
  wire capture  = hit & idle;
  wire clr_both = reg_we & (reg_wdata[1:0] == 2'b11);
  wire fix_read = ev_valid & ecc_en & ev_ce & ~ev_ue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbe_q       <= 1'b0;
      mbe_q       <= 1'b0;
      addr_q      <= '0;
      syn_q       <= '0;
      scrub_off_q <= 1'b0;
      serr_en_q   <= 1'b0;
      nmi_en_q    <= 1'b0;
    end else begin
      if (reg_we) begin
        scrub_off_q <= reg_wdata[31];
        serr_en_q   <= reg_wdata[3];
        nmi_en_q    <= reg_wdata[2];
      end
      if (capture) begin
        mbe_q  <= ev_ue;
        sbe_q  <= ~ev_ue;
        addr_q <= ev_addr[ADDR_W-1:LOW_W];
        syn_q  <= ev_syn;
      end else if (clr_both) begin
        sbe_q <= 1'b0;
        mbe_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_req_o  <= 1'b0;
      scrub_addr_o <= '0;
    end else begin
      scrub_req_o <= fix_read & ~scrub_off_q;
      if (fix_read) scrub_addr_o <= ev_addr;
    end
  end

  assign reg_rdata = {scrub_off_q, addr_q, syn_q, serr_en_q, nmi_en_q, mbe_q, sbe_q};
  assign nmi_o     = sbe_q & nmi_en_q;
  assign serr_o    = mbe_q & serr_en_q;
endmodule

module ecc_err_logger_chk #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ecc_en,
  input logic              ev_valid,
  input logic              ev_ce,
  input logic              ev_ue,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              nmi_o,
  input logic              serr_o,
  input logic              scrub_req_o
);
  assert_one_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rdata[0] && reg_rdata[1]));

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] != 2'b00) |=> $stable(reg_rdata[30:4]));

  assert_partial_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[1:0] != 2'b11 && reg_rdata[1:0] != 2'b00)
      |=> $stable(reg_rdata[1:0]));

  assert_no_log_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_en && !reg_we) |=> $stable(reg_rdata[30:0]));

  assert_nmi_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> reg_rdata[0] && reg_rdata[2]);

  assert_serr_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serr_o) |-> reg_rdata[1] && reg_rdata[3]);

  assert_scrub_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ecc_en && ev_ce && !ev_ue && !reg_rdata[31]) |=> scrub_req_o);

  assert_scrub_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid || !ecc_en || !ev_ce || ev_ue || reg_rdata[31]) |=> !scrub_req_o);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ev_valid(ev_valid), .ev_ce(ev_ce),
  .ev_ue(ev_ue), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .nmi_o(nmi_o), .serr_o(serr_o), .scrub_req_o(scrub_req_o)
);

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_en = 1'b0, ev_valid = 1'b0, ev_ce = 1'b0, ev_ue = 1'b0;
  logic [31:0] ev_addr = '0;
  logic [7:0]  ev_syn = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_o, serr_o, scrub_req_o;
  logic [31:0] scrub_addr_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ecc_err_logger u_dut (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ev_valid(ev_valid), .ev_ce(ev_ce),
    .ev_ue(ev_ue), .ev_addr(ev_addr), .ev_syn(ev_syn), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_o(nmi_o), .serr_o(serr_o),
    .scrub_req_o(scrub_req_o), .scrub_addr_o(scrub_addr_o)
  );

  // bench model state
  logic        m_sbe, m_mbe, m_off, m_serr_en, m_nmi_en, m_scrub;
  logic [18:0] m_addr;
  logic [7:0]  m_syn;
  logic [31:0] m_saddr;

  function automatic logic [31:0] exp_word();
    return {m_off, m_addr, m_syn, m_serr_en, m_nmi_en, m_mbe, m_sbe};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_sbe = 0; m_mbe = 0; m_off = 0; m_serr_en = 0; m_nmi_en = 0;
    m_scrub = 0; m_addr = '0; m_syn = '0; m_saddr = '0;
  endtask

  // advance the model by one edge using current inputs
  task automatic model_step();
    logic logd, fix;
    logd = ev_valid && ecc_en && (ev_ce || ev_ue) && !m_sbe && !m_mbe;
    fix  = ev_valid && ecc_en && ev_ce && !ev_ue;
    m_scrub = fix && !m_off;
    if (fix) m_saddr = ev_addr;
    if (logd) begin
      m_mbe = ev_ue; m_sbe = !ev_ue;
      m_addr = ev_addr[31:13]; m_syn = ev_syn;
    end else if (reg_we && reg_wdata[1:0] == 2'b11) begin
      m_sbe = 0; m_mbe = 0;
    end
    if (reg_we) begin
      m_off = reg_wdata[31]; m_serr_en = reg_wdata[3]; m_nmi_en = reg_wdata[2];
    end
  endtask

  // drive at negedge, clock once, compare at next negedge
  task automatic cyc(logic en, logic v, logic ce, logic ue, logic [31:0] a,
                     logic [7:0] s, logic we, logic [31:0] wd);
    ecc_en = en; ev_valid = v; ev_ce = ce; ev_ue = ue; ev_addr = a; ev_syn = s;
    reg_we = we; reg_wdata = wd;
    model_step();
    @(negedge clk);
  endtask

  task automatic chk_all(string tag);
    chk({tag, " word"}, reg_rdata, exp_word());
    chk("R7 nmi", {31'd0, nmi_o}, {31'd0, m_sbe & m_nmi_en});
    chk("R7 serr", {31'd0, serr_o}, {31'd0, m_mbe & m_serr_en});
    chk("R8 scrub", {31'd0, scrub_req_o}, {31'd0, m_scrub});
    if (m_scrub) chk("R8 scrub addr", scrub_addr_o, m_saddr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_all("R1 reset");
    chk("R1 nmi", {31'd0, nmi_o}, 32'd0);
    chk("R1 scrub", {31'd0, scrub_req_o}, 32'd0);

    // R2: corrected read with enables on
    cyc(1,0,0,0,0,0,1,32'h0000_000C); chk_all("R6 enables");
    cyc(1,1,1,0,32'hDEAD_BEEF,8'h5A,0,0); chk_all("R2 ce log");
    chk("R2 sbe", {31'd0, reg_rdata[0]}, 32'd1);
    chk("R2 addr", {13'd0, reg_rdata[30:12]}, {13'd0, 19'(32'hDEAD_BEEF >> 13)});
    chk("R7 nmi high", {31'd0, nmi_o}, 32'd1);
    // R4: later ue not recorded
    cyc(1,1,0,1,32'h1234_5678,8'hC3,0,0); chk_all("R4 frozen");
    chk("R4 mbe stays 0", {31'd0, reg_rdata[1]}, 32'd0);
    // R5: partial clears ignored
    cyc(1,0,0,0,0,0,1,32'h0000_000D); chk_all("R5 partial 01");
    chk("R5 sbe kept", {31'd0, reg_rdata[0]}, 32'd1);
    cyc(1,0,0,0,0,0,1,32'h0000_000E); chk_all("R5 partial 10");
    cyc(1,0,0,0,0,0,1,32'h0000_000F); chk_all("R5 clear both");
    chk("R5 flags clear", {30'd0, reg_rdata[1:0]}, 32'd0);
    // R3: both at once -> multi-bit
    cyc(1,1,1,1,32'hF000_2000,8'h81,0,0); chk_all("R3 both");
    chk("R3 mbe only", {30'd0, reg_rdata[1:0]}, 32'd2);
    chk("R7 serr high", {31'd0, serr_o}, 32'd1);
    cyc(1,0,0,0,0,0,1,32'h0000_0003); chk_all("R5 clear mbe");
    // R8: scrub disabled
    cyc(1,0,0,0,0,0,1,32'h8000_0000); chk_all("R6 scrub off");
    cyc(1,1,1,0,32'h0000_4000,8'h11,0,0); chk_all("R8 no scrub when off");
    cyc(1,0,0,0,0,0,1,32'h0000_0003); chk_all("R5 clear");
    // R9: ecc disabled
    cyc(0,1,1,0,32'hAAAA_0000,8'h22,0,0); chk_all("R9 off ce");
    cyc(0,1,0,1,32'hBBBB_0000,8'h33,0,0); chk_all("R9 off ue");
    chk("R9 flags", {30'd0, reg_rdata[1:0]}, 32'd0);

    // random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] != 0, r[4], r[5], r[6] & r[7], $urandom, 8'($urandom),
          r[11:9] == 0, {r[12], 27'($urandom), r[14:13], (r[15] ? 2'b11 : r[17:16])});
      chk_all("R2 R3 R4 R5 R6 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule